// File: doc/BRIEF.md
# PLL Divider Search Engine

This block chooses divider settings for a frequency synthesizer. The synthesizer's output is the reference frequency times a feedback divider, divided by a pre-divider. A start pulse supplies two unsigned 32-bit integers in Hz: the reference clock frequency and the requested high-speed bit rate. The engine then tries each legal pre-divider in turn. For each one it derives the feedback divider and the frequency that pair would produce. It keeps the pair that lands closest to the target.

The engine first halves the reference. It then caps the target at 1 GHz. From the halved reference it computes the window of pre-dividers that keeps the divided reference between 5 MHz and 40 MHz. It walks that window from the low end upward. Every quotient comes from one shared restoring divider that produces one quotient bit per clock, and all products are formed at 64 bits. The search stops early on an exact hit. When it finishes, the engine pulses `done_o` and presents the chosen pre-divider, feedback divider and reached frequency, along with a found flag.

Top module: `pll_div_search`

## Requirements
- R1: All calculations use half of `ref_hz_i`, rounded down, as the effective reference (fref).
- R2: A requested rate above 1,000,000,000 is replaced by exactly 1,000,000,000 before searching. A request of 2.5 GHz therefore gives the same result as a request of 1 GHz.
- R3: The pre-divider is swept upward from ceil(fref / 40,000,000) to floor(fref / 5,000,000), both ends included. The lower end is raised to 1 if it computes as 0. An empty window yields no candidate.
- R4: For each pre-divider p, the candidate feedback divider is floor(target × p / fref). The reached frequency is floor(fb × fref / p). The error is the absolute difference between the reached frequency and the capped target.
- R5: A candidate feedback divider below 12, above 511, or equal to 15 is skipped. Any reported `fbdiv_o` is always in the legal set.
- R6: A candidate with zero error ends the search at once and is reported, so `freq_o` equals the target. A search that hits exactly at its first pre-divider completes sooner than a full sweep over the same window.
- R7: A candidate replaces the stored best only when its error is strictly smaller. Among equal errors, the one with the lowest pre-divider is reported.
- R8: If no legal candidate exists, `found_o` is low after `done_o`, and `prediv_o`, `fbdiv_o` and `freq_o` keep the values they had before the search.
- R9: A start pulse while `busy_o` is high is ignored: the running search finishes with the result for the inputs it captured. A start pulse while idle raises `busy_o` on the next cycle.
- R10: `done_o` is a single-cycle pulse that coincides with `busy_o` falling. The three result outputs change only in the cycle `done_o` is high. `found_o` is cleared when a search is accepted.
- R11: After reset, `busy_o`, `done_o` and `found_o` are low and all three result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; inputs are captured when idle |
| ref_hz_i | input | 32 | Reference clock frequency in Hz |
| rate_hz_i | input | 32 | Requested bit rate in Hz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | A legal pair was found by the last search |
| prediv_o | output | 16 | Chosen pre-divider |
| fbdiv_o | output | 9 | Chosen feedback divider |
| freq_o | output | 32 | Frequency reached by the chosen pair in Hz |

## Verification
An error in the window arithmetic or the legality filter changes which pre-divider wins. It appears at the ports as a different `prediv_o`/`fbdiv_o` pair at the very next `done_o`. A wrong comparison rule shows up on a tie only as a later pre-divider, and a missing early exit shows up only as a longer start-to-done latency. Directed cases are therefore built so that the winner depends on the tie order, on the feedback gap at 15, on the lower window edge and on the rate cap. Randomly chosen references and rates are then compared against a bench model.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MINP,
        S_MAXP,
        S_CHK,
        S_FBQ,
        S_FRQ,
        S_EVAL
    } srch_st_e;

endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
    parameter int W     = 64,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         fin
);

    typedef struct packed {
        logic             run;
        logic             fin;
        logic [CNT_W-1:0] cnt;
        logic [W:0]       rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     dsr;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [W:0] shifted;
    logic       take;

    always_comb begin
        st_d    = st_q;
        st_d.fin = 1'b0;
        shifted = {st_q.rem[W-1:0], st_q.quo[W-1]};
        take    = (shifted >= {1'b0, st_q.dsr});
        if (go) begin
            st_d.run = 1'b1;
            st_d.cnt = CNT_W'(W);
            st_d.rem = '0;
            st_d.quo = dividend;
            st_d.dsr = divisor;
        end else if (st_q.run) begin
            st_d.rem = take ? (shifted - {1'b0, st_q.dsr}) : shifted;
            st_d.quo = {st_q.quo[W-2:0], take};
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.run = 1'b0;
                st_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quotient = st_q.quo;
    assign fin      = st_q.fin;

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_srch_pkg::*;
#(
    parameter int unsigned FRQ_W       = 32,
    parameter int unsigned PRE_W       = 16,
    parameter int unsigned PFD_MAX_HZ  = 40_000_000,
    parameter int unsigned PFD_MIN_HZ  = 5_000_000,
    parameter int unsigned RATE_CAP_HZ = 1_000_000_000,
    parameter int unsigned FB_MIN      = 12,
    parameter int unsigned FB_MAX      = 511,
    parameter int unsigned FB_GAP      = 15,
    localparam int unsigned FB_W       = $clog2(FB_MAX + 1),
    localparam int unsigned PROD_W     = 2 * FRQ_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [FRQ_W-1:0] ref_hz_i,
    input  logic [FRQ_W-1:0] rate_hz_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             found_o,
    output logic [PRE_W-1:0] prediv_o,
    output logic [FB_W-1:0]  fbdiv_o,
    output logic [FRQ_W-1:0] freq_o
);

    localparam logic [PROD_W-1:0] PRE_SAT = PROD_W'({PRE_W{1'b1}});
    localparam logic [PROD_W-1:0] FRQ_SAT = PROD_W'({FRQ_W{1'b1}});

    typedef struct packed {
        srch_st_e         st;
        logic             go;
        logic [FRQ_W-1:0] fref;
        logic [FRQ_W-1:0] tgt;
        logic [PRE_W-1:0] pre;
        logic [PRE_W-1:0] pre_max;
        logic [FB_W-1:0]  fb;
        logic [FRQ_W-1:0] frq;
        logic             have;
        logic [PRE_W-1:0] b_pre;
        logic [FB_W-1:0]  b_fb;
        logic [FRQ_W-1:0] b_frq;
        logic [FRQ_W-1:0] b_err;
        logic             done;
        logic             found;
        logic [PRE_W-1:0] o_pre;
        logic [FB_W-1:0]  o_fb;
        logic [FRQ_W-1:0] o_frq;
    } srch_state_t;

    srch_state_t s_d, s_q;

    logic [PROD_W-1:0] dvd, dsr, quo;
    logic              div_fin;
    logic              fb_ok;
    logic [FRQ_W-1:0]  err;

    always_comb begin
        dvd = PROD_W'(s_q.fref);
        dsr = PROD_W'(PFD_MIN_HZ);
        unique case (s_q.st)
            S_MINP: begin
                dvd = PROD_W'(s_q.fref) + PROD_W'(PFD_MAX_HZ - 1);
                dsr = PROD_W'(PFD_MAX_HZ);
            end
            S_FBQ: begin
                dvd = PROD_W'(s_q.tgt) * PROD_W'(s_q.pre);
                dsr = PROD_W'(s_q.fref);
            end
            S_FRQ: begin
                dvd = PROD_W'(s_q.fb) * PROD_W'(s_q.fref);
                dsr = PROD_W'(s_q.pre);
            end
            default: ;
        endcase
    end

    pll_srch_div #(.W(PROD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (s_q.go),
        .dividend (dvd),
        .divisor  (dsr),
        .quotient (quo),
        .fin      (div_fin)
    );

    assign fb_ok = (quo >= PROD_W'(FB_MIN)) && (quo <= PROD_W'(FB_MAX))
                && (quo != PROD_W'(FB_GAP));
    assign err   = (s_q.tgt >= s_q.frq) ? (s_q.tgt - s_q.frq) : (s_q.frq - s_q.tgt);

    always_comb begin
        s_d      = s_q;
        s_d.go   = 1'b0;
        s_d.done = 1'b0;
        unique case (s_q.st)
            S_IDLE: if (start_i) begin
                s_d.fref  = ref_hz_i >> 1;
                s_d.tgt   = (rate_hz_i > FRQ_W'(RATE_CAP_HZ)) ? FRQ_W'(RATE_CAP_HZ) : rate_hz_i;
                s_d.found = 1'b0;
                s_d.have  = 1'b0;
                s_d.st    = S_MINP;
                s_d.go    = 1'b1;
            end
            S_MINP: if (div_fin) begin
                if (quo == '0)        s_d.pre = PRE_W'(1);
                else if (quo > PRE_SAT) s_d.pre = '1;
                else                  s_d.pre = quo[PRE_W-1:0];
                s_d.st = S_MAXP;
                s_d.go = 1'b1;
            end
            S_MAXP: if (div_fin) begin
                s_d.pre_max = (quo > PRE_SAT) ? '1 : quo[PRE_W-1:0];
                s_d.st      = S_CHK;
            end
            S_CHK: begin
                if (s_q.pre > s_q.pre_max || s_q.pre == '1) begin
                    s_d.st    = S_IDLE;
                    s_d.done  = 1'b1;
                    s_d.found = s_q.have;
                    if (s_q.have) begin
                        s_d.o_pre = s_q.b_pre;
                        s_d.o_fb  = s_q.b_fb;
                        s_d.o_frq = s_q.b_frq;
                    end
                end else begin
                    s_d.st = S_FBQ;
                    s_d.go = 1'b1;
                end
            end
            S_FBQ: if (div_fin) begin
                if (fb_ok) begin
                    s_d.fb = quo[FB_W-1:0];
                    s_d.st = S_FRQ;
                    s_d.go = 1'b1;
                end else begin
                    s_d.pre = s_q.pre + 1'b1;
                    s_d.st  = S_CHK;
                end
            end
            S_FRQ: if (div_fin) begin
                s_d.frq = (quo > FRQ_SAT) ? '1 : quo[FRQ_W-1:0];
                s_d.st  = S_EVAL;
            end
            S_EVAL: begin
                if (err == '0) begin
                    s_d.st    = S_IDLE;
                    s_d.done  = 1'b1;
                    s_d.found = 1'b1;
                    s_d.o_pre = s_q.pre;
                    s_d.o_fb  = s_q.fb;
                    s_d.o_frq = s_q.frq;
                end else begin
                    if (!s_q.have || err < s_q.b_err) begin
                        s_d.have  = 1'b1;
                        s_d.b_pre = s_q.pre;
                        s_d.b_fb  = s_q.fb;
                        s_d.b_frq = s_q.frq;
                        s_d.b_err = err;
                    end
                    s_d.pre = s_q.pre + 1'b1;
                    s_d.st  = S_CHK;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o   = (s_q.st != S_IDLE);
    assign done_o   = s_q.done;
    assign found_o  = s_q.found;
    assign prediv_o = s_q.o_pre;
    assign fbdiv_o  = s_q.o_fb;
    assign freq_o   = s_q.o_frq;

endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
    parameter int unsigned FRQ_W  = 32,
    parameter int unsigned PRE_W  = 16,
    parameter int unsigned FB_W   = 9,
    parameter int unsigned FB_MIN = 12,
    parameter int unsigned FB_MAX = 511,
    parameter int unsigned FB_GAP = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             found_o,
    input logic [PRE_W-1:0] prediv_o,
    input logic [FB_W-1:0]  fbdiv_o,
    input logic [FRQ_W-1:0] freq_o
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(prediv_o) && $stable(fbdiv_o) && $stable(freq_o))); // R8

    AST_FB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (fbdiv_o >= FB_W'(FB_MIN) && fbdiv_o <= FB_W'(FB_MAX)
                     && fbdiv_o != FB_W'(FB_GAP))); // R5

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R9

    AST_FOUND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !found_o); // R10

    AST_PRE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (prediv_o != '0)); // R3

endmodule

bind pll_div_search pll_div_search_chk #(
    .FRQ_W (FRQ_W),
    .PRE_W (PRE_W),
    .FB_W  (FB_W),
    .FB_MIN(FB_MIN),
    .FB_MAX(FB_MAX),
    .FB_GAP(FB_GAP)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .found_o (found_o),
    .prediv_o(prediv_o),
    .fbdiv_o (fbdiv_o),
    .freq_o  (freq_o)
);

// File: tb/pll_div_search_bench.sv
`timescale 1ns/1ps
module pll_div_search_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ref_hz_i = '0;
    logic [31:0] rate_hz_i = '0;
    logic        busy_o, done_o, found_o;
    logic [15:0] prediv_o;
    logic [8:0]  fbdiv_o;
    logic [31:0] freq_o;

    int checks = 0;
    int fails = 0;
    bit ended = 1'b0;

    longint unsigned e_pre = 0, e_fb = 0, e_frq = 0;

    always #2 clk = ~clk;

    pll_div_search u_pll_div_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ref_hz_i(ref_hz_i), .rate_hz_i(rate_hz_i),
        .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
        .prediv_o(prediv_o), .fbdiv_o(fbdiv_o), .freq_o(freq_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference search from the requirements
    function automatic void model(input longint unsigned rf, input longint unsigned rt,
                                  output bit fnd, output longint unsigned p_o,
                                  output longint unsigned f_o, output longint unsigned q_o);
        longint unsigned fref, tgt, mn, mx, fb, fq, e, best;
        fref = rf / 2;
        tgt  = (rt > 64'd1_000_000_000) ? 64'd1_000_000_000 : rt;
        mn   = (fref + 64'd39_999_999) / 64'd40_000_000;
        if (mn == 0) mn = 1;
        mx   = fref / 64'd5_000_000;
        fnd = 0; p_o = 0; f_o = 0; q_o = 0; best = 0;
        for (longint unsigned p = mn; p <= mx; p++) begin
            fb = (tgt * p) / fref;
            if (fb < 12 || fb > 511 || fb == 15) continue;
            fq = (fb * fref) / p;
            e  = (tgt > fq) ? tgt - fq : fq - tgt;
            if (e == 0) begin
                fnd = 1; p_o = p; f_o = fb; q_o = fq;
                break;
            end else if (!fnd || e < best) begin
                fnd = 1; p_o = p; f_o = fb; q_o = fq; best = e;
            end
        end
    endfunction

    task automatic run_case(input longint unsigned rf, input longint unsigned rt,
                            input string req, input bit poke, output int lat);
        bit fnd;
        longint unsigned mp, mf, mq;
        @(negedge clk);
        ref_hz_i = rf[31:0]; rate_hz_i = rt[31:0]; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after start", longint'(busy_o), 1);
        chk(found_o == 1'b0, "R10", "found cleared", longint'(found_o), 0);
        lat = 1;
        if (poke) begin
            repeat (40) @(negedge clk);
            lat += 40;
            ref_hz_i = 32'd48_000_000; rate_hz_i = 32'd481_000_000; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; lat++;
            ref_hz_i = rf[31:0]; rate_hz_i = rt[31:0];
        end
        while (!done_o && lat < 30000) begin
            @(negedge clk);
            lat++;
        end
        chk(done_o == 1'b1, req, "done before timeout", longint'(done_o), 1);
        model(rf, rt, fnd, mp, mf, mq);
        if (fnd) begin
            e_pre = mp; e_fb = mf; e_frq = mq;
        end
        chk(found_o == fnd, req, "found", longint'(found_o), longint'(fnd));
        chk(prediv_o == e_pre[15:0], req, "prediv", longint'(prediv_o), e_pre);
        chk(fbdiv_o == e_fb[8:0], req, "fbdiv", longint'(fbdiv_o), e_fb);
        chk(freq_o == e_frq[31:0], req, "freq", longint'(freq_o), e_frq);
        chk(busy_o == 1'b0, "R10", "idle with done", longint'(busy_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R10", "done one cycle", longint'(done_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat, lat_exact, lat_full;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy_o == 0 && done_o == 0 && found_o == 0, "R11", "flags in reset",
            longint'({busy_o, done_o, found_o}), 0);
        chk(prediv_o == 0 && fbdiv_o == 0 && freq_o == 0, "R11", "results in reset",
            longint'(freq_o) + longint'(prediv_o) + longint'(fbdiv_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R4 basic: fref 12 MHz
        run_case(64'd24_000_000, 64'd500_000_000, "R4", 1'b0, lat);
        // R7 tie: every prediv reaches 480 MHz, the first must win
        run_case(64'd48_000_000, 64'd481_000_000, "R7", 1'b0, lat);
        chk(prediv_o == 1 && fbdiv_o == 20 && freq_o == 32'd480_000_000, "R7",
            "earliest tie prediv", longint'(prediv_o), 1);
        // R5 gap: prediv 1 gives fb 15 and is skipped
        run_case(64'd40_000_000, 64'd300_000_000, "R5", 1'b0, lat);
        chk(prediv_o == 2 && fbdiv_o == 30, "R5", "skip fb 15", longint'(prediv_o), 2);
        // R2 clamp
        run_case(64'd48_000_000, 64'd2_500_000_000, "R2", 1'b0, lat);
        chk(prediv_o == 3 && fbdiv_o == 125 && freq_o == 32'd1_000_000_000, "R2",
            "clamped result", longint'(freq_o), 64'd1_000_000_000);
        // R3 lower window edge at 3: prediv 2 would hit exactly
        run_case(64'd200_000_000, 64'd950_000_000, "R3", 1'b0, lat);
        chk(prediv_o == 4 && fbdiv_o == 38, "R3", "window start", longint'(prediv_o), 4);
        // R3 R8 empty window, outputs kept
        run_case(64'd8_000_000, 64'd500_000_000, "R8", 1'b0, lat);
        chk(found_o == 0 && prediv_o == 4, "R8", "empty window keeps outputs",
            longint'(prediv_o), 4);
        // R5 R8 all candidates illegal
        run_case(64'd100_000_000, 64'd10_000_000, "R8", 1'b0, lat);
        chk(found_o == 0 && fbdiv_o == 38, "R8", "illegal only keeps outputs",
            longint'(fbdiv_o), 38);
        // R6 early exit
        run_case(64'd50_000_000, 64'd500_000_000, "R6", 1'b0, lat_exact);
        chk(freq_o == 32'd500_000_000 && prediv_o == 1, "R6", "exact hit",
            longint'(freq_o), 64'd500_000_000);
        run_case(64'd50_000_000, 64'd501_000_000, "R6", 1'b0, lat_full);
        chk(lat_exact < lat_full, "R6", "exact exits sooner", lat_exact, lat_full);
        // R9 start while busy ignored
        run_case(64'd100_000_000, 64'd777_000_000, "R9", 1'b1, lat);
        // random
        for (int i = 0; i < 40; i++) begin
            longint unsigned rf, rt;
            rf = 64'd10_000_000 + longint'($urandom % 32'd110_000_000);
            rt = 64'd50_000_000 + longint'($urandom % 32'd1_200_000_000);
            run_case(rf, rt, "R4", 1'b0, lat);
        end
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule